// File: doc/BRIEF.md
# Issue Window Wakeup Logic

This block is the wakeup half of an out-of-order scheduler. It holds up to `WIN` waiting instructions. Each one carries two physical source register tags, a ready flag per source, and a destination tag. Each cycle, up to `IW` result tags arrive on an external broadcast bus. Every waiting source tag is compared against every valid lane, and the per-lane hits are ORed into that source's ready flag. An entry raises its request line to the select stage once it is valid and both of its sources are ready.

The window also announces its own issued instructions. When select grants an entry, the entry is freed and its destination tag is driven on an internal broadcast bus in the next cycle. That bus is also exported, so the register file and bypass network can expect the result two cycles later. Dependent instructions in the same window wake from that bus exactly as they do from the external one. This lets a consumer request issue while its producer is still in the pipeline.

New instructions enter through a single dispatch port. Each one is placed in the lowest-numbered free entry, and a full flag tells the dispatcher when to hold off. A flush input empties the whole window in one cycle.

Top module: `issue_wakeup_window`

## Requirements
- R1: After a synchronous active-low reset, every request bit, every self-broadcast valid bit and the full flag are 0.
- R2: Request bit i is 1 exactly when entry i is valid and both of its source ready flags are set; flags written at dispatch are visible the cycle after.
- R3: A valid entry whose source is not ready sets that source's ready flag on the clock edge that ends a cycle in which any valid broadcast lane carries an equal tag; once set, the flag stays set while the entry lives.
- R4: Each of the `IW` external lanes is compared independently (lane k occupies tag bits [k*TW +: TW], valid bit k); a lane whose valid bit is 0 never wakes a source.
- R5: A source presented at dispatch as not ready is nonetheless recorded as ready if its tag matches a valid broadcast lane (external or self) in the dispatch cycle.
- R6: A grant accepted for entry i in cycle t clears entry i at the end of t, so its request bit is 0 from cycle t+1 on.
- R7: In cycle t+1 the self-broadcast bus carries the destination tags of the grants accepted in cycle t, packed into lanes from lane 0 upward in ascending entry order; this bus wakes window entries exactly like the external bus.
- R8: A grant bit on an entry whose request bit is 0 is ignored: no entry changes and no tag is broadcast for it.
- R9: A dispatch is written into the lowest-indexed invalid entry; the full flag is 1 exactly when all entries are valid.
- R10: If more than `IW` requesting entries are granted in one cycle, only the `IW` lowest-indexed ones are accepted; the rest stay valid and keep requesting.
- R11: Flush clears all entries and all self-broadcast valid bits at the next edge; a dispatch or grant in the flush cycle has no effect.
- R12: A dispatch presented while the full flag is 1 is dropped and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Empty the window at the next edge |
| disp_vld_i | input | 1 | Dispatch an instruction this cycle |
| disp_src1_i | input | TW | First source physical tag |
| disp_rdy1_i | input | 1 | First source already available |
| disp_src2_i | input | TW | Second source physical tag |
| disp_rdy2_i | input | 1 | Second source already available |
| disp_dst_i | input | TW | Destination physical tag |
| ext_vld_i | input | IW | Valid bit per external broadcast lane |
| ext_tag_i | input | IW*TW | External broadcast tags, lane k at [k*TW +: TW] |
| grant_i | input | WIN | Per-entry grant from the select stage |
| req_o | output | WIN | Per-entry issue request |
| bc_vld_o | output | IW | Valid bit per self-broadcast lane |
| bc_tag_o | output | IW*TW | Self-broadcast destination tags |
| win_full_o | output | 1 | All entries occupied |

## Verification
The bench builds the window with 4 entries, 2 broadcast lanes and 4-bit tags. With four entries, the full flag and the dropped-dispatch case take only a few dispatches to reach. Two lanes make three simultaneous grants enough to exercise the acceptance cap and the ascending lane packing. Sixteen tag values make accidental tag matches during the random phase frequent, so same-cycle dispatch wakeups and wakeups from the self-broadcast bus occur many times.

// File: rtl/wk_pkg.sv
// Package: shared helpers for the issue window wakeup block.
// Assumes nothing beyond the parameters passed by its users.
package wk_pkg;
    // Number of compare lanes seen by each source tag: external plus self bus.
    function automatic int unsigned wk_lanes(input int unsigned iw);
        return 2 * iw;
    endfunction
endpackage

// File: rtl/wk_tag_cam.sv
// Module: one source-tag comparator against a bus of broadcast lanes.
// Does: compares tag_i with every lane and ORs the valid matches.
// Assumes: lane k occupies bus_i[k*TW +: TW] and is qualified by vld_i[k].
module wk_tag_cam #(
    parameter int unsigned TW = 6,
    parameter int unsigned NB = 4
) (
    input  logic [TW-1:0]    tag_i,
    input  logic [NB-1:0]    vld_i,
    input  logic [NB*TW-1:0] bus_i,
    output logic             hit_o
);
    logic [NB-1:0] lane_hit;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        // Per-lane equality, gated by the lane valid bit.
        assign lane_hit[k] = vld_i[k] && (bus_i[k*TW +: TW] == tag_i);
    end

    // OR of all lane matches.
    assign hit_o = |lane_hit;
endmodule

// File: rtl/wk_entry.sv
// Module: one issue window slot.
// Does: holds valid, two source tags with ready flags and a destination tag;
//       wakes sources from the broadcast bus; requests when fully ready.
// Assumes: wr_i only targets an invalid slot; free_i only when requesting.
module wk_entry #(
    parameter int unsigned TW = 6,
    parameter int unsigned NB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_i,
    input  logic [TW-1:0]    src1_i,
    input  logic             rdy1_i,
    input  logic [TW-1:0]    src2_i,
    input  logic             rdy2_i,
    input  logic [TW-1:0]    dst_i,
    input  logic             free_i,
    input  logic [NB-1:0]    bus_vld_i,
    input  logic [NB*TW-1:0] bus_tag_i,
    output logic             valid_o,
    output logic             req_o,
    output logic [TW-1:0]    dst_o
);
    logic          valid_q, rdy1_q, rdy2_q;
    logic [TW-1:0] src1_q, src2_q, dst_q;
    logic          hit1, hit2;

    wk_tag_cam #(.TW(TW), .NB(NB)) u_cam1 (
        .tag_i(src1_q), .vld_i(bus_vld_i), .bus_i(bus_tag_i), .hit_o(hit1)
    );
    wk_tag_cam #(.TW(TW), .NB(NB)) u_cam2 (
        .tag_i(src2_q), .vld_i(bus_vld_i), .bus_i(bus_tag_i), .hit_o(hit2)
    );

    // Slot state: reset/flush/free empty it, dispatch fills it, wakeup sets flags.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            valid_q <= 1'b0;
            rdy1_q  <= 1'b0;
            rdy2_q  <= 1'b0;
            src1_q  <= '0;
            src2_q  <= '0;
            dst_q   <= '0;
        end else if (free_i) begin
            valid_q <= 1'b0;
        end else if (wr_i) begin
            valid_q <= 1'b1;
            src1_q  <= src1_i;
            src2_q  <= src2_i;
            dst_q   <= dst_i;
            rdy1_q  <= rdy1_i;
            rdy2_q  <= rdy2_i;
        end else if (valid_q) begin
            rdy1_q  <= rdy1_q | hit1;
            rdy2_q  <= rdy2_q | hit2;
        end
    end

    assign valid_o = valid_q;
    assign req_o   = valid_q & rdy1_q & rdy2_q;
    assign dst_o   = dst_q;

    a_r6_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
        free_i |=> !valid_q);
    a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !valid_q);
    a_r3_wake_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && hit1 && !free_i && !flush_i) |=> (valid_q && rdy1_q));
    a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && rdy2_q && !free_i && !flush_i) |=> rdy2_q);
endmodule

// File: rtl/wk_self_bcast.sv
// Module: grant acceptance and self-broadcast register.
// Does: accepts at most IW requesting grants (lowest index first), packs their
//       destination tags into lanes 0 upward and registers them for one cycle.
// Assumes: dst_i holds entry i's destination at [i*TW +: TW].
module wk_self_bcast #(
    parameter int unsigned WIN = 16,
    parameter int unsigned IW  = 2,
    parameter int unsigned TW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [WIN-1:0]    grant_i,
    input  logic [WIN-1:0]    req_i,
    input  logic [WIN*TW-1:0] dst_i,
    output logic [WIN-1:0]    acc_o,
    output logic [IW-1:0]     bc_vld_o,
    output logic [IW*TW-1:0]  bc_tag_o
);
    logic [IW-1:0]    slot_vld;
    logic [IW*TW-1:0] slot_tag;
    logic [IW-1:0]    bc_vld_q;
    logic [IW*TW-1:0] bc_tag_q;

    // Accept grants in ascending entry order until IW lanes are used.
    always_comb begin
        int cnt;
        cnt      = 0;
        acc_o    = '0;
        slot_vld = '0;
        slot_tag = '0;
        for (int i = 0; i < int'(WIN); i++) begin
            if (grant_i[i] && req_i[i] && cnt < int'(IW)) begin
                acc_o[i] = 1'b1;
                for (int k = 0; k < int'(IW); k++) begin
                    if (k == cnt) begin
                        slot_vld[k]          = 1'b1;
                        slot_tag[k*TW +: TW] = dst_i[i*TW +: TW];
                    end
                end
                cnt = cnt + 1;
            end
        end
    end

    // One-cycle broadcast register, squashed by flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            bc_vld_q <= '0;
            bc_tag_q <= '0;
        end else begin
            bc_vld_q <= slot_vld;
            bc_tag_q <= slot_tag;
        end
    end

    assign bc_vld_o = bc_vld_q;
    assign bc_tag_o = bc_tag_q;

    a_r7_lane0_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ((|acc_o) && !flush_i) |=> bc_vld_q[0]);
    a_r7_no_bcast_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o == '0) |=> (bc_vld_q == '0));
    a_r10_accept_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(acc_o) <= IW);
endmodule

// File: rtl/issue_wakeup_window.sv
// Module: issue window wakeup top.
// Does: dispatch into the lowest free slot, wakeup against external and self
//       broadcast lanes, request generation, grant-driven free and broadcast.
// Assumes: the dispatcher honours win_full_o; select grants only requesters.
module issue_wakeup_window
    import wk_pkg::*;
#(
    parameter int unsigned WIN = 16,
    parameter int unsigned IW  = 2,
    parameter int unsigned TW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              disp_vld_i,
    input  logic [TW-1:0]     disp_src1_i,
    input  logic              disp_rdy1_i,
    input  logic [TW-1:0]     disp_src2_i,
    input  logic              disp_rdy2_i,
    input  logic [TW-1:0]     disp_dst_i,
    input  logic [IW-1:0]     ext_vld_i,
    input  logic [IW*TW-1:0]  ext_tag_i,
    input  logic [WIN-1:0]    grant_i,
    output logic [WIN-1:0]    req_o,
    output logic [IW-1:0]     bc_vld_o,
    output logic [IW*TW-1:0]  bc_tag_o,
    output logic              win_full_o
);
    localparam int unsigned NB = wk_lanes(IW);

    logic [NB-1:0]    bus_vld;
    logic [NB*TW-1:0] bus_tag;
    logic [WIN-1:0]   valid, acc, alloc;
    logic [WIN*TW-1:0] dst;
    logic             dhit1, dhit2;

    // Merged wakeup bus: self lanes above external lanes.
    assign bus_vld = {bc_vld_o, ext_vld_i};
    assign bus_tag = {bc_tag_o, ext_tag_i};

    wk_tag_cam #(.TW(TW), .NB(NB)) u_dcam1 (
        .tag_i(disp_src1_i), .vld_i(bus_vld), .bus_i(bus_tag), .hit_o(dhit1)
    );
    wk_tag_cam #(.TW(TW), .NB(NB)) u_dcam2 (
        .tag_i(disp_src2_i), .vld_i(bus_vld), .bus_i(bus_tag), .hit_o(dhit2)
    );

    // Pick the lowest invalid slot for a dispatch.
    always_comb begin
        logic found;
        found = 1'b0;
        alloc = '0;
        for (int i = 0; i < int'(WIN); i++) begin
            if (disp_vld_i && !valid[i] && !found) begin
                alloc[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    for (genvar i = 0; i < WIN; i++) begin : g_ent
        wk_entry #(.TW(TW), .NB(NB)) u_ent (
            .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
            .wr_i(alloc[i]),
            .src1_i(disp_src1_i), .rdy1_i(disp_rdy1_i | dhit1),
            .src2_i(disp_src2_i), .rdy2_i(disp_rdy2_i | dhit2),
            .dst_i(disp_dst_i),
            .free_i(acc[i]),
            .bus_vld_i(bus_vld), .bus_tag_i(bus_tag),
            .valid_o(valid[i]), .req_o(req_o[i]), .dst_o(dst[i*TW +: TW])
        );
    end

    wk_self_bcast #(.WIN(WIN), .IW(IW), .TW(TW)) u_bcast (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .grant_i(grant_i), .req_i(req_o), .dst_i(dst),
        .acc_o(acc), .bc_vld_o(bc_vld_o), .bc_tag_o(bc_tag_o)
    );

    assign win_full_o = &valid;

    a_r12_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        win_full_o |-> (alloc == '0));
    a_r9_single_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc));
    a_r8_accept_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc & ~req_o) == '0));
endmodule

// File: tb/issue_wakeup_window_bench.sv
`timescale 1ns/1ps
module issue_wakeup_window_bench;
    localparam int WIN = 4;
    localparam int IW  = 2;
    localparam int TW  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush_i = 1'b0;
    logic              disp_vld_i = 1'b0;
    logic [TW-1:0]     disp_src1_i = '0, disp_src2_i = '0, disp_dst_i = '0;
    logic              disp_rdy1_i = 1'b0, disp_rdy2_i = 1'b0;
    logic [IW-1:0]     ext_vld_i = '0;
    logic [IW*TW-1:0]  ext_tag_i = '0;
    logic [WIN-1:0]    grant_i = '0;
    logic [WIN-1:0]    req_o;
    logic [IW-1:0]     bc_vld_o;
    logic [IW*TW-1:0]  bc_tag_o;
    logic              win_full_o;

    issue_wakeup_window #(.WIN(WIN), .IW(IW), .TW(TW)) u_issue_wakeup_window (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .disp_vld_i(disp_vld_i), .disp_src1_i(disp_src1_i), .disp_rdy1_i(disp_rdy1_i),
        .disp_src2_i(disp_src2_i), .disp_rdy2_i(disp_rdy2_i), .disp_dst_i(disp_dst_i),
        .ext_vld_i(ext_vld_i), .ext_tag_i(ext_tag_i), .grant_i(grant_i),
        .req_o(req_o), .bc_vld_o(bc_vld_o), .bc_tag_o(bc_tag_o), .win_full_o(win_full_o)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    int checks = 0, failures = 0;
    bit done = 0;
    string cur = "R1";

    // Reference model state.
    int mv[WIN], ms1[WIN], ms2[WIN], md[WIN], mr1[WIN], mr2[WIN];
    int mbv[IW], mbt[IW];

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic bit m_hit(input int tag);
        for (int k = 0; k < IW; k++) begin
            if (ext_vld_i[k] && int'(ext_tag_i[k*TW +: TW]) == tag) return 1;
            if (mbv[k] != 0 && mbt[k] == tag) return 1;
        end
        return 0;
    endfunction

    function automatic bit m_req(input int i);
        return mv[i] != 0 && mr1[i] != 0 && mr2[i] != 0;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < WIN; i++) begin
            mv[i] = 0; ms1[i] = 0; ms2[i] = 0; md[i] = 0; mr1[i] = 0; mr2[i] = 0;
        end
        for (int k = 0; k < IW; k++) begin mbv[k] = 0; mbt[k] = 0; end
    endtask

    // Compare outputs at the falling edge, then advance the model over one clock.
    task automatic cyc();
        logic [WIN-1:0] ereq;
        logic [IW-1:0]  ebv;
        logic [IW*TW-1:0] etag, mask;
        bit efull;
        int acc[WIN];
        int nbv[IW], nbt[IW];
        int cnt, al;
        efull = 1;
        for (int i = 0; i < WIN; i++) begin
            ereq[i] = m_req(i);
            if (mv[i] == 0) efull = 0;
        end
        etag = '0; mask = '0;
        for (int k = 0; k < IW; k++) begin
            ebv[k] = (mbv[k] != 0);
            if (mbv[k] != 0) begin
                etag[k*TW +: TW] = mbt[k][TW-1:0];
                mask[k*TW +: TW] = '1;
            end
        end
        chk(req_o === ereq, cur, "req", longint'(req_o), longint'(ereq));
        chk(bc_vld_o === ebv && (bc_tag_o & mask) === etag, cur, "bcast",
            longint'({bc_vld_o, bc_tag_o & mask}), longint'({ebv, etag}));
        chk(win_full_o === efull, cur, "full", longint'(win_full_o), longint'(efull));
        // Next state.
        cnt = 0;
        for (int k = 0; k < IW; k++) begin nbv[k] = 0; nbt[k] = 0; end
        for (int i = 0; i < WIN; i++) begin
            acc[i] = 0;
            if (grant_i[i] && m_req(i) && cnt < IW) begin
                acc[i] = 1; nbv[cnt] = 1; nbt[cnt] = md[i]; cnt++;
            end
        end
        al = -1;
        if (disp_vld_i) begin
            for (int i = WIN - 1; i >= 0; i--) if (mv[i] == 0) al = i;
        end
        for (int i = 0; i < WIN; i++) begin
            if (flush_i) mv[i] = 0;
            else if (acc[i] != 0) mv[i] = 0;
            else if (al == i) begin
                mv[i] = 1; ms1[i] = int'(disp_src1_i); ms2[i] = int'(disp_src2_i);
                md[i] = int'(disp_dst_i);
                mr1[i] = int'(disp_rdy1_i | m_hit(int'(disp_src1_i)));
                mr2[i] = int'(disp_rdy2_i | m_hit(int'(disp_src2_i)));
            end else if (mv[i] != 0) begin
                if (m_hit(ms1[i])) mr1[i] = 1;
                if (m_hit(ms2[i])) mr2[i] = 1;
            end
        end
        for (int k = 0; k < IW; k++) begin
            mbv[k] = flush_i ? 0 : nbv[k];
            mbt[k] = nbt[k];
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        flush_i = 0; disp_vld_i = 0; ext_vld_i = '0; grant_i = '0;
        disp_rdy1_i = 0; disp_rdy2_i = 0;
    endtask

    task automatic disp(input int s1, input bit r1, input int s2, input bit r2, input int d);
        disp_vld_i = 1;
        disp_src1_i = s1[TW-1:0]; disp_rdy1_i = r1;
        disp_src2_i = s2[TW-1:0]; disp_rdy2_i = r2;
        disp_dst_i = d[TW-1:0];
    endtask

    task automatic ext(input int lane, input int tag);
        ext_vld_i[lane] = 1'b1;
        ext_tag_i[lane*TW +: TW] = tag[TW-1:0];
    endtask

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state.
        cur = "R1"; idle(); cyc();
        // R2: fully ready dispatch requests next cycle.
        cur = "R2"; disp(1, 1, 2, 1, 9); cyc(); idle(); cyc();
        chk(req_o[0] === 1'b1, "R2", "entry0 req", req_o[0], 1);
        // R3/R4: waiting entry woken by lane 1, invalid lane 0 carrying the tag ignored.
        cur = "R4"; disp(5, 0, 6, 1, 10); cyc(); idle();
        ext_tag_i[0 +: TW] = 4'd5; ext_vld_i = 2'b00; cyc();
        chk(req_o[1] === 1'b0, "R4", "invalid lane no wake", req_o[1], 0);
        cur = "R3"; idle(); ext(1, 5); cyc(); idle(); cyc();
        chk(req_o[1] === 1'b1, "R3", "woken entry1", req_o[1], 1);
        // R5: dispatch-cycle match.
        cur = "R5"; disp(7, 0, 8, 0, 11); ext(0, 7); ext(1, 8); cyc(); idle(); cyc();
        chk(req_o[2] === 1'b1, "R5", "same-cycle wake", req_o[2], 1);
        // R8: grant on non-requesting entry 3 (empty) ignored.
        cur = "R8"; grant_i = 4'b1000; cyc(); idle(); cyc();
        // R6/R7: grant entry0 (dst 9); dependent waits on 9 and wakes from self bus.
        cur = "R6"; disp(9, 0, 9, 0, 12); grant_i = 4'b0001; cyc(); idle();
        cur = "R7"; chk(bc_vld_o[0] === 1'b1 && bc_tag_o[0 +: TW] === 4'd9, "R7",
                        "self lane0", longint'(bc_tag_o), 9);
        cyc(); cyc();
        // R9/R12: window full now; extra dispatch dropped.
        cur = "R9"; disp(1, 1, 1, 1, 13); cyc(); idle(); cyc();
        cur = "R12"; disp(2, 1, 2, 1, 14); cyc(); idle(); cyc();
        // R10: grant all four; only two lowest accepted.
        cur = "R10"; grant_i = 4'b1111; cyc(); idle(); cyc(); cyc();
        // R11: flush with a simultaneous dispatch and grant.
        cur = "R11"; flush_i = 1; disp(3, 1, 3, 1, 15); grant_i = req_o; cyc(); idle(); cyc();
        chk(req_o === '0 && bc_vld_o === '0, "R11", "flushed", longint'(req_o), 0);
        // Random phase across all rules.
        cur = "R3";
        for (int n = 0; n < 400; n++) begin
            idle();
            if ($urandom_range(0, 3) != 0)
                disp($urandom_range(0, 15), 1'($urandom_range(0, 1)),
                     $urandom_range(0, 15), 1'($urandom_range(0, 1)), $urandom_range(0, 15));
            ext_vld_i = 2'($urandom_range(0, 3));
            ext_tag_i = 8'($urandom_range(0, 255));
            grant_i = 4'($urandom_range(0, 15));
            flush_i = ($urandom_range(0, 40) == 0);
            cyc();
        end
        idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule